// File: doc/BRIEF.md
# Indexed Configuration Register Space

This block holds the configuration state of a multi-function peripheral controller and exposes it through two byte-wide ports on an 8-bit I/O bus. One port takes a register number and the other carries the data. Software first writes an unlock key to the index port. It then writes a register number to the index port and reads or writes that register through the data port. Writing the relock key to the index port closes access again.

Most registers come in one copy per logical device, and a global device-number register chooses which copy the data port reaches. Each device has an enable bit, a 16-bit I/O base address, two interrupt numbers, a DMA channel and a few device-specific mode bytes. A small set of global registers holds two power-down control bytes and a self-clearing soft-reset command. That command returns every device copy, the device number and the power-down bytes to zero. All stored values leave the block as flat per-device vectors for the peripheral logic.

Top module: `cfg_regspace`

## Requirements
- R1: While locked, a write of 0x51 to the index port (port_sel=0) unlocks the space. While unlocked, a write of 0xBB to the index port locks it again and leaves the selected register number unchanged. After reset the space is locked.
- R2: While locked, data-port writes (port_sel=1) have no effect, and index-port writes other than 0x51 do not change the selected register number. A data-port read returns 0x00 while locked, and a read with port_sel=0 always returns 0x00.
- R3: While unlocked, any other index-port write selects that register number. A data-port write or read in a later cycle reaches that register. A write takes effect at the next clock edge, and a read returns the value combinationally.
- R4: Global index 0x07 holds the device number. Banked registers read and write only the copy of the currently selected device, and the other devices' copies keep their values.
- R5: Bit 0 of banked index 0x30 is the device enable. It reads back as {7'b0, enable} and drives bit i of dev_active.
- R6: Banked indices 0x60 and 0x61 hold the high and low bytes of the device base address. The address drives dev_base[16*i +: 16].
- R7: Banked index 0x70 holds the primary interrupt number, 0x72 the second interrupt number and 0x74 the DMA channel. These drive dev_irq_a, dev_irq_b and dev_dma at [8*i +: 8].
- R8: Banked indices 0xF0 to 0xF0+MODES-1 are full-byte mode registers. Mode byte k of device i drives dev_mode[8*(i*MODES+k) +: 8].
- R9: Global indices 0x22 and 0x23 hold the direct and automatic power-down bytes, which drive pd_direct and pd_auto. They do not depend on the device number.
- R10: A data write to global index 0x02 with bit 0 set clears every device copy, the device number and both power-down bytes at the next edge. The lock state and the selected register number are kept. A write there with bit 0 clear has no effect, and index 0x02 reads 0x00.
- R11: Indices that are not implemented read 0x00 and ignore writes, and this includes mode indices at or above 0xF0+MODES. When the device number is NUM_DEV or higher, banked reads return 0x00 and banked writes are ignored.
- R12: After reset, every enable, base address, interrupt number, DMA channel, mode byte, power-down byte and the device number are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, zero when not reading the open data port |
| dev_active | output | NUM_DEV | Enable bit per device |
| dev_base | output | 16*NUM_DEV | Base address per device |
| dev_irq_a | output | 8*NUM_DEV | Primary interrupt number per device |
| dev_irq_b | output | 8*NUM_DEV | Second interrupt number per device |
| dev_dma | output | 8*NUM_DEV | DMA channel per device |
| dev_mode | output | 8*MODES*NUM_DEV | Mode bytes per device |
| pd_direct | output | 8 | Direct power-down byte |
| pd_auto | output | 8 | Automatic power-down byte |

## Verification
The assertions check several properties on every cycle. Locked-state writes must leave the device number, the power-down bytes and the selected register number unchanged. The unlock and relock keys must take effect on the next cycle. A soft reset must clear every copy. A device copy must not change in a cycle without its own write strobe. Banked reads under an out-of-range device number must return zero. The bench scenarios are needed for behaviour that is only visible in the data-port contents and the per-device output slices. These include bank isolation between particular devices, full-byte mode storage, the index being retained across relock and soft reset, and unimplemented indices reading zero.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [7:0] IDX_SRST  = 8'h02;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam logic [7:0] IDX_PDD   = 8'h22;
  localparam logic [7:0] IDX_PDA   = 8'h23;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] IDX_BASEH = 8'h60;
  localparam logic [7:0] IDX_BASEL = 8'h61;
  localparam logic [7:0] IDX_IRQA  = 8'h70;
  localparam logic [7:0] IDX_IRQB  = 8'h72;
  localparam logic [7:0] IDX_DMA   = 8'h74;
  localparam logic [7:0] IDX_MODE0 = 8'hF0;
  localparam logic [7:0] KEY_OPEN  = 8'h51;
  localparam logic [7:0] KEY_CLOSE = 8'hBB;

  typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} port_e;
endpackage

// File: rtl/cfg_port_ctl.sv
module cfg_port_ctl
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_sel,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic [7:0] index
);
  logic       unl_q, unl_d;
  logic [7:0] idx_q, idx_d;
  logic       idx_en;
  logic       idx_wr;

  assign idx_wr = wr_en && (port_e'(port_sel) == PORT_INDEX);

  always_comb begin
    unl_d  = unl_q;
    idx_d  = idx_q;
    idx_en = 1'b0;
    if (idx_wr) begin
      if (!unl_q) begin
        if (wdata == KEY_OPEN) unl_d = 1'b1;
      end else if (wdata == KEY_CLOSE) begin
        unl_d = 1'b0;
      end else begin
        idx_en = 1'b1;
        idx_d  = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q <= 1'b0;
      idx_q <= 8'h00;
    end else begin
      unl_q <= unl_d;
      if (idx_en) idx_q <= idx_d;
    end
  end

  assign unlocked = unl_q;
  assign index    = idx_q;

  // R1
  open_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && idx_wr && wdata == KEY_OPEN) |=> unl_q);
  // R1
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unl_q && idx_wr && wdata == KEY_CLOSE) |=> (!unl_q && $stable(idx_q)));
  // R2
  locked_index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q) |=> $stable(idx_q));
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_pkg::*;
#(
  parameter int MODES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               wr_en,
  input  logic [7:0]         idx,
  input  logic [7:0]         wdata,
  output logic [7:0]         rd_data,
  output logic               active,
  output logic [15:0]        base,
  output logic [7:0]         irq_a,
  output logic [7:0]         irq_b,
  output logic [7:0]         dma,
  output logic [MODES*8-1:0] mode
);
  logic              act_q, act_d;
  logic [15:0]       base_q, base_d;
  logic [7:0]        irqa_q, irqa_d, irqb_q, irqb_d, dma_q, dma_d;
  logic [7:0]        mode_q [MODES];
  logic [7:0]        mode_d [MODES];
  logic [MODES-1:0]  mode_hit;
  logic              bank_en;

  for (genvar k = 0; k < MODES; k++) begin : g_hit
    assign mode_hit[k] = (idx == IDX_MODE0 + 8'(k));
    assign mode[k*8 +: 8] = mode_q[k];
  end

  assign bank_en = soft_rst || wr_en;

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    irqa_d = irqa_q;
    irqb_d = irqb_q;
    dma_d  = dma_q;
    for (int k = 0; k < MODES; k++) mode_d[k] = mode_q[k];
    if (soft_rst) begin
      act_d  = 1'b0;
      base_d = 16'h0000;
      irqa_d = 8'h00;
      irqb_d = 8'h00;
      dma_d  = 8'h00;
      for (int k = 0; k < MODES; k++) mode_d[k] = 8'h00;
    end else if (wr_en) begin
      case (idx)
        IDX_ACT:   act_d         = wdata[0];
        IDX_BASEH: base_d[15:8]  = wdata;
        IDX_BASEL: base_d[7:0]   = wdata;
        IDX_IRQA:  irqa_d        = wdata;
        IDX_IRQB:  irqb_d        = wdata;
        IDX_DMA:   dma_d         = wdata;
        default: begin
          for (int k = 0; k < MODES; k++)
            if (mode_hit[k]) mode_d[k] = wdata;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= 16'h0000;
      irqa_q <= 8'h00;
      irqb_q <= 8'h00;
      dma_q  <= 8'h00;
      for (int k = 0; k < MODES; k++) mode_q[k] <= 8'h00;
    end else if (bank_en) begin
      act_q  <= act_d;
      base_q <= base_d;
      irqa_q <= irqa_d;
      irqb_q <= irqb_d;
      dma_q  <= dma_d;
      for (int k = 0; k < MODES; k++) mode_q[k] <= mode_d[k];
    end
  end

  always_comb begin
    rd_data = 8'h00;
    case (idx)
      IDX_ACT:   rd_data = {7'b0, act_q};
      IDX_BASEH: rd_data = base_q[15:8];
      IDX_BASEL: rd_data = base_q[7:0];
      IDX_IRQA:  rd_data = irqa_q;
      IDX_IRQB:  rd_data = irqb_q;
      IDX_DMA:   rd_data = dma_q;
      default: begin
        for (int k = 0; k < MODES; k++)
          if (mode_hit[k]) rd_data = mode_q[k];
      end
    endcase
  end

  assign active = act_q;
  assign base   = base_q;
  assign irq_a  = irqa_q;
  assign irq_b  = irqb_q;
  assign dma    = dma_q;

  // R10
  bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!act_q && base_q == 16'h0 && irqa_q == 8'h0 && irqb_q == 8'h0 && dma_q == 8'h0));
  // R4
  bank_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !soft_rst) |=> ($stable(act_q) && $stable(base_q) && $stable(irqa_q) && $stable(dma_q)));
endmodule

// File: rtl/cfg_regspace.sv
module cfg_regspace
  import cfg_pkg::*;
#(
  parameter int NUM_DEV = 6,
  parameter int MODES   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       port_sel,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic [NUM_DEV-1:0]         dev_active,
  output logic [NUM_DEV*16-1:0]      dev_base,
  output logic [NUM_DEV*8-1:0]       dev_irq_a,
  output logic [NUM_DEV*8-1:0]       dev_irq_b,
  output logic [NUM_DEV*8-1:0]       dev_dma,
  output logic [NUM_DEV*MODES*8-1:0] dev_mode,
  output logic [7:0]                 pd_direct,
  output logic [7:0]                 pd_auto
);
  localparam int MODE_W = MODES * 8;

  logic             unlocked;
  logic [7:0]       idx;
  logic             data_wr, soft_rst, is_global, ldn_valid;
  logic [7:0]       ldn_q, ldn_d, pdd_q, pdd_d, pda_q, pda_d;
  logic             glb_en;
  logic [NUM_DEV-1:0] bank_wr;
  logic [7:0]       bank_rd [NUM_DEV];
  logic [7:0]       bank_sel_rd;

  cfg_port_ctl u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_sel (port_sel),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .unlocked (unlocked),
    .index    (idx)
  );

  assign data_wr   = wr_en && (port_e'(port_sel) == PORT_DATA) && unlocked;
  assign is_global = (idx == IDX_SRST) || (idx == IDX_LDN) ||
                     (idx == IDX_PDD)  || (idx == IDX_PDA);
  assign soft_rst  = data_wr && (idx == IDX_SRST) && wdata[0];
  assign ldn_valid = (ldn_q < 8'(NUM_DEV));

  always_comb begin
    ldn_d  = ldn_q;
    pdd_d  = pdd_q;
    pda_d  = pda_q;
    glb_en = 1'b0;
    if (soft_rst) begin
      glb_en = 1'b1;
      ldn_d  = 8'h00;
      pdd_d  = 8'h00;
      pda_d  = 8'h00;
    end else if (data_wr) begin
      glb_en = 1'b1;
      case (idx)
        IDX_LDN: ldn_d = wdata;
        IDX_PDD: pdd_d = wdata;
        IDX_PDA: pda_d = wdata;
        default: glb_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldn_q <= 8'h00;
      pdd_q <= 8'h00;
      pda_q <= 8'h00;
    end else if (glb_en) begin
      ldn_q <= ldn_d;
      pdd_q <= pdd_d;
      pda_q <= pda_d;
    end
  end

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign bank_wr[i] = data_wr && !is_global && (ldn_q == 8'(i));
    cfg_dev_bank #(.MODES(MODES)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (bank_wr[i]),
      .idx      (idx),
      .wdata    (wdata),
      .rd_data  (bank_rd[i]),
      .active   (dev_active[i]),
      .base     (dev_base[i*16 +: 16]),
      .irq_a    (dev_irq_a[i*8 +: 8]),
      .irq_b    (dev_irq_b[i*8 +: 8]),
      .dma      (dev_dma[i*8 +: 8]),
      .mode     (dev_mode[i*MODE_W +: MODE_W])
    );
  end

  always_comb begin
    bank_sel_rd = 8'h00;
    for (int i = 0; i < NUM_DEV; i++)
      if (ldn_q == 8'(i)) bank_sel_rd = bank_rd[i];
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en && (port_e'(port_sel) == PORT_DATA) && unlocked) begin
      case (idx)
        IDX_SRST: rdata = 8'h00;
        IDX_LDN:  rdata = ldn_q;
        IDX_PDD:  rdata = pdd_q;
        IDX_PDA:  rdata = pda_q;
        default:  rdata = ldn_valid ? bank_sel_rd : 8'h00;
      endcase
    end
  end

  assign pd_direct = pdd_q;
  assign pd_auto   = pda_q;

  // R2
  locked_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked) |=> ($stable(ldn_q) && $stable(pdd_q) && $stable(pda_q) && $stable(dev_base)));
  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked) |-> (rdata == 8'h00));
  // R10
  srst_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ldn_q == 8'h00 && pdd_q == 8'h00 && pda_q == 8'h00 && dev_active == '0));
  // R11
  bad_ldn_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldn_valid && !is_global) |-> (rdata == 8'h00));
  // R4
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));
endmodule

// File: tb/tb_cfg_regspace.sv
module tb_cfg_regspace;
  localparam int NUM_DEV = 6;
  localparam int MODES   = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic port_sel, wr_en, rd_en;
  logic [7:0] wdata, rdata;
  logic [NUM_DEV-1:0]         dev_active;
  logic [NUM_DEV*16-1:0]      dev_base;
  logic [NUM_DEV*8-1:0]       dev_irq_a, dev_irq_b, dev_dma;
  logic [NUM_DEV*MODES*8-1:0] dev_mode;
  logic [7:0] pd_direct, pd_auto;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t exp_q[$];
  logic [7:0] act_q[$];

  always #2.5 clk = ~clk;

  cfg_regspace #(.NUM_DEV(NUM_DEV), .MODES(MODES)) dut (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .dev_active(dev_active), .dev_base(dev_base),
    .dev_irq_a(dev_irq_a), .dev_irq_b(dev_irq_b), .dev_dma(dev_dma),
    .dev_mode(dev_mode), .pd_direct(pd_direct), .pd_auto(pd_auto)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    port_sel = sel; wr_en = 1'b1; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    bus_wr(1'b0, i);
    bus_wr(1'b1, v);
  endtask

  task automatic data_rd_exp(input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    port_sel = 1'b1; rd_en = 1'b1;
    it.v = exp; it.tag = tag;
    exp_q.push_back(it);
    #1;
    act_q.push_back(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] i, input logic [7:0] exp, input string tag);
    bus_wr(1'b0, i);
    data_rd_exp(exp, tag);
  endtask

  always @(posedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t it;
      logic [7:0] a;
      it = exp_q.pop_front();
      a  = act_q.pop_front();
      chk(it.tag, {24'h0, a}, {24'h0, it.v});
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; port_sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state at the ports
    chk("R12 active", {26'h0, dev_active}, 32'h0);
    chk("R12 base", dev_base[31:0], 32'h0);
    chk("R12 pd", {16'h0, pd_direct, pd_auto}, 32'h0);
    chk("R12 mode", dev_mode[31:0], 32'h0);

    // R2 locked: index write and data write ignored, read returns zero
    bus_wr(1'b0, 8'h07);
    bus_wr(1'b1, 8'h03);
    data_rd_exp(8'h00, "R2 locked read");
    set_reg(8'h22, 8'h99);
    chk("R2 locked pd write", {24'h0, pd_direct}, 32'h0);

    // R1 unlock, R3 index/data, R4 device number register
    bus_wr(1'b0, 8'h51);
    rd_exp(8'h07, 8'h00, "R2 locked ldn write ignored");
    set_reg(8'h07, 8'h01);
    rd_exp(8'h07, 8'h01, "R1 R3 R4 ldn readback");

    // R5..R8 device 1
    set_reg(8'h30, 8'hFF);
    set_reg(8'h60, 8'h03);
    set_reg(8'h61, 8'hF8);
    set_reg(8'h70, 8'h04);
    set_reg(8'h72, 8'h0C);
    set_reg(8'h74, 8'h03);
    set_reg(8'hF0, 8'hA5);
    set_reg(8'hF3, 8'h3C);
    chk("R5 active", {26'h0, dev_active}, 32'h2);
    chk("R6 base", {16'h0, dev_base[16 +: 16]}, 32'h03F8);
    chk("R7 irq_a", {24'h0, dev_irq_a[8 +: 8]}, 32'h04);
    chk("R7 irq_b", {24'h0, dev_irq_b[8 +: 8]}, 32'h0C);
    chk("R7 dma", {24'h0, dev_dma[8 +: 8]}, 32'h03);
    chk("R8 mode0", {24'h0, dev_mode[(1*MODES+0)*8 +: 8]}, 32'hA5);
    chk("R8 mode3", {24'h0, dev_mode[(1*MODES+3)*8 +: 8]}, 32'h3C);
    rd_exp(8'h30, 8'h01, "R5 active readback");
    rd_exp(8'h61, 8'hF8, "R6 low readback");
    rd_exp(8'hF3, 8'h3C, "R8 mode readback");

    // R4 other banks
    set_reg(8'h07, 8'h04);
    set_reg(8'h60, 8'h02);
    set_reg(8'h61, 8'hF8);
    set_reg(8'h07, 8'h05);
    set_reg(8'h60, 8'h03);
    set_reg(8'h61, 8'hE8);
    chk("R4 dev4 base", {16'h0, dev_base[64 +: 16]}, 32'h02F8);
    chk("R4 dev5 base", {16'h0, dev_base[80 +: 16]}, 32'h03E8);
    chk("R4 dev1 kept", {16'h0, dev_base[16 +: 16]}, 32'h03F8);
    rd_exp(8'h60, 8'h03, "R4 dev5 read");
    set_reg(8'h07, 8'h00);
    rd_exp(8'h60, 8'h00, "R4 dev0 read");

    // R9 global power-down
    set_reg(8'h22, 8'h5A);
    set_reg(8'h23, 8'h81);
    set_reg(8'h07, 8'h03);
    rd_exp(8'h22, 8'h5A, "R9 pd direct read");
    chk("R9 pd ports", {16'h0, pd_direct, pd_auto}, 32'h5A81);

    // R11 unimplemented and out-of-range device
    set_reg(8'h40, 8'h77);
    data_rd_exp(8'h00, "R11 unimpl index");
    set_reg(8'hF4, 8'h66);
    data_rd_exp(8'h00, "R11 mode beyond range");
    set_reg(8'h07, 8'h06);
    set_reg(8'h60, 8'h12);
    data_rd_exp(8'h00, "R11 bad ldn read");
    rd_exp(8'h07, 8'h06, "R11 ldn value kept");
    chk("R11 bank0 untouched", {16'h0, dev_base[0 +: 16]}, 32'h0);
    chk("R11 bank5 untouched", {16'h0, dev_base[80 +: 16]}, 32'h03E8);

    // R10 soft reset
    set_reg(8'h02, 8'hFE);
    chk("R10 bit0 clear no effect", {16'h0, dev_base[16 +: 16]}, 32'h03F8);
    set_reg(8'h02, 8'h01);
    chk("R10 active cleared", {26'h0, dev_active}, 32'h0);
    chk("R10 base cleared", {16'h0, dev_base[16 +: 16]}, 32'h0);
    chk("R10 mode cleared", {24'h0, dev_mode[(1*MODES+0)*8 +: 8]}, 32'h0);
    chk("R10 pd cleared", {16'h0, pd_direct, pd_auto}, 32'h0);
    data_rd_exp(8'h00, "R10 reg reads zero");
    rd_exp(8'h07, 8'h00, "R10 ldn cleared");
    set_reg(8'h07, 8'h02);
    data_rd_exp(8'h02, "R10 still unlocked");

    // R1 relock keeps index; R2 locked writes ignored
    bus_wr(1'b0, 8'hBB);
    bus_wr(1'b0, 8'h22);
    bus_wr(1'b1, 8'h09);
    data_rd_exp(8'h00, "R1 relocked read");
    bus_wr(1'b0, 8'h51);
    data_rd_exp(8'h02, "R1 index kept over relock");

    // R2 read on index port returns zero
    @(negedge clk);
    port_sel = 1'b0; rd_en = 1'b1;
    #1;
    chk("R2 index port read", {24'h0, rdata}, 32'h0);
    @(negedge clk);
    rd_en = 1'b0;

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule